// File: doc/BRIEF.md
# Bus Handshake Rule Monitor

This block is a passive observer placed on a single-requester peripheral bus link using the APB handshake. It drives nothing onto the bus. On every rising clock edge it looks at the select vector, the enable strobe, the address, the direction, the write data and byte strobes, the ready return and the error return. From these it decides whether any handshake rule was broken in that cycle. Six rules are tracked, and each one has its own numeric identifier.

An internal phase tracker follows each transfer through three phases: idle, setup, and waiting-in-access. Alongside it run a field-hold comparator and a saturating wait-state counter. A violation sets that rule's bit in a sticky register, and only reset clears that register. On the clock edge after the offending cycle, the monitor also gives a single-cycle pulse together with a rule identifier. When several rules break in the same cycle, the identifier names the lowest-numbered one. The wait-state limit `MAX_WAIT` (written N below) is a parameter.

While reset is active, every check is off. After reset is released, the monitor stays silent until it observes a setup cycle, so a transfer that reset cut short is never reported.

Top module: `apb_rule_monitor`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it is released, `viol_sticky` is all-zero, `viol_pulse` is 0 and `viol_id` is 0.
- R2: Rule 0 (field hold) fires when `req_addr`, `req_write`, `req_wdata` or `req_strb` differs from the value it had in the setup cycle, in any later cycle of the same transfer up to and including the completing cycle. Changes made after completion are not violations.
- R3: Rule 1 (enable order) fires when `req_enable` is high with every select bit low. It also fires when `req_enable` is high in the first selected cycle of a transfer that does not directly follow a completion.
- R4: Rule 2 (select conflict) fires in any cycle where two or more bits of `req_sel` are high. All-zero and single-bit patterns are legal.
- R5: Rule 3 (timeout) fires exactly once, on the (N+1)th consecutive access cycle (select and enable high) with `cpl_ready` low. A transfer that waits N cycles or fewer never fires it, and the wait counter saturates at N+1.
- R6: Rule 4 (error position) fires when `cpl_err` is high in a cycle where select, enable and ready are not all high. An error reported in the completing cycle is legal.
- R7: Rule 5 (back-to-back) fires when the cycle right after a completion has select and enable both high. A new transfer that starts with enable low directly after a completion is legal.
- R8: A rule firing sets bit k of `viol_sticky`, where k is the rule number above. Once set, the bit stays set until reset.
- R9: If any rule fires in cycle t, `viol_pulse` is high for exactly the cycle after t, and `viol_id` holds the lowest-numbered rule that fired in t. If no rule fires in t, `viol_pulse` is low in the cycle after t.
- R10: Once reset has been released, no rule fires until a setup cycle is seen, that is, a cycle with some select bit high and `req_enable` low. That setup cycle is itself checked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all sampling on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_sel | input | SEL_W | Completer select vector |
| req_enable | input | 1 | Enable strobe marking the access phase |
| req_addr | input | ADDR_W | Transfer address |
| req_write | input | 1 | Direction, 1 = write |
| req_wdata | input | DATA_W | Write data |
| req_strb | input | DATA_W/8 | Write byte strobes |
| cpl_ready | input | 1 | Completer ready |
| cpl_err | input | 1 | Completer error response |
| viol_sticky | output | 6 | Sticky flags, bit k = rule k has fired |
| viol_pulse | output | 1 | One-cycle pulse, the cycle after any violation |
| viol_id | output | 3 | Lowest-numbered rule that fired in the previous cycle |

## Verification
The timeout rule and the field-hold rule can fire in the same cycle. The bench provokes this by holding a transfer in the wait state for exactly N cycles and then flipping an address bit on the (N+1)th waiting cycle. The result is judged correct when the sticky register shows both bit 0 and bit 3 set, while the pulse on the next sample carries identifier 0, not 3. The priority encoding is also exercised by an error-strobe sweep: placing the error where an enable-order violation happens at the same time must report rule 1 ahead of rule 4.

// File: rtl/apb_mon_pkg.sv
package apb_mon_pkg;

  localparam int RULE_CNT  = 6;
  localparam int RULE_ID_W = 3;

  // Rule numbering sets the reporting priority: the lowest number wins.
  localparam int RL_HOLD     = 0;
  localparam int RL_ENABLE   = 1;
  localparam int RL_MULTISEL = 2;
  localparam int RL_TIMEOUT  = 3;
  localparam int RL_ERRPOS   = 4;
  localparam int RL_B2B      = 5;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACCESS = 2'd2
  } phase_t;

  function automatic logic [RULE_ID_W-1:0] lowest_rule(input logic [RULE_CNT-1:0] hits);
    logic [RULE_ID_W-1:0] id;
    id = '0;
    for (int i = RULE_CNT - 1; i >= 0; i--) begin
      if (hits[i]) id = RULE_ID_W'(i);
    end
    return id;
  endfunction

endpackage

// File: rtl/apb_mon_phase.sv
module apb_mon_phase
  import apb_mon_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   any_sel,
  input  logic   enable,
  input  logic   ready,
  output phase_t st_q,
  output logic   done_q,
  output logic   chk_en
);

  logic   armed_q;
  logic   setup_now;
  phase_t st_d;

  assign setup_now = any_sel & ~enable;
  // Checking begins with the first setup cycle observed after reset.
  assign chk_en    = armed_q | setup_now;

  always_comb begin
    if (!chk_en || !any_sel) st_d = PH_IDLE;
    else if (!enable)        st_d = PH_SETUP;
    else if (ready)          st_d = PH_IDLE;
    else                     st_d = PH_ACCESS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= PH_IDLE;
      done_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      done_q  <= chk_en & any_sel & enable & ready;
      armed_q <= chk_en;
    end
  end

endmodule

// File: rtl/apb_mon_hold.sv
module apb_mon_hold #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int STRB_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              compare,
  input  logic [ADDR_W-1:0] addr,
  input  logic              write,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STRB_W-1:0] strb,
  output logic              mismatch
);

  localparam int FIELD_W = ADDR_W + 1 + DATA_W + STRB_W;

  logic [FIELD_W-1:0] live;
  logic [FIELD_W-1:0] held_q;

  assign live     = {addr, write, wdata, strb};
  assign mismatch = compare & (live != held_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held_q <= '0;
    else if (capture) held_q <= live;
  end

endmodule

// File: rtl/apb_mon_wait_timer.sv
module apb_mon_wait_timer #(
  parameter  int LIMIT = 8,
  localparam int CW    = $clog2(LIMIT + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          waiting,
  output logic [CW-1:0] cnt_q,
  output logic          expired
);

  // Counts up while waiting and stops at LIMIT+1, so a hang is reported once.
  function automatic logic [CW-1:0] sat_step(input logic [CW-1:0] c);
    if (c >= CW'(LIMIT + 1)) return c;
    return c + 1'b1;
  endfunction

  assign expired = waiting & (cnt_q == CW'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (waiting) cnt_q <= sat_step(cnt_q);
    else              cnt_q <= '0;
  end

endmodule

// File: rtl/apb_rule_monitor.sv
module apb_rule_monitor
  import apb_mon_pkg::*;
#(
  parameter int SEL_W    = 4,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int MAX_WAIT = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SEL_W-1:0]       req_sel,
  input  logic                   req_enable,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic                   req_write,
  input  logic [DATA_W-1:0]      req_wdata,
  input  logic [DATA_W/8-1:0]    req_strb,
  input  logic                   cpl_ready,
  input  logic                   cpl_err,
  output logic [RULE_CNT-1:0]    viol_sticky,
  output logic                   viol_pulse,
  output logic [RULE_ID_W-1:0]   viol_id
);

  localparam int STRB_W  = DATA_W / 8;
  localparam int WAIT_CW = $clog2(MAX_WAIT + 2);

  function automatic logic sel_conflict(input logic [SEL_W-1:0] s);
    return (s & (s - 1'b1)) != '0;
  endfunction

  // Named events, brought out for the checker.
  logic               any_sel;
  logic               access_now;
  logic               complete_now;
  logic               waiting;
  logic               chk_en;
  logic               done_q;
  logic               phase_open;
  logic               hold_mismatch;
  logic               timer_expired;
  logic [WAIT_CW-1:0] wait_cnt;
  phase_t             st_q;
  logic [RULE_CNT-1:0] rule_raw;
  logic [RULE_CNT-1:0] rule_fire;

  assign any_sel      = |req_sel;
  assign access_now   = any_sel & req_enable;
  assign complete_now = access_now & cpl_ready;
  assign waiting      = chk_en & access_now & ~cpl_ready;
  assign phase_open   = (st_q != PH_IDLE);

  apb_mon_phase u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .any_sel (any_sel),
    .enable  (req_enable),
    .ready   (cpl_ready),
    .st_q    (st_q),
    .done_q  (done_q),
    .chk_en  (chk_en)
  );

  apb_mon_hold #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .STRB_W (STRB_W)
  ) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (any_sel & ~phase_open),
    .compare  (any_sel & phase_open),
    .addr     (req_addr),
    .write    (req_write),
    .wdata    (req_wdata),
    .strb     (req_strb),
    .mismatch (hold_mismatch)
  );

  apb_mon_wait_timer #(
    .LIMIT (MAX_WAIT)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .waiting (waiting),
    .cnt_q   (wait_cnt),
    .expired (timer_expired)
  );

  always_comb begin
    rule_raw              = '0;
    rule_raw[RL_HOLD]     = hold_mismatch;
    rule_raw[RL_ENABLE]   = (req_enable & ~any_sel)
                          | (access_now & (st_q == PH_IDLE) & ~done_q);
    rule_raw[RL_MULTISEL] = sel_conflict(req_sel);
    rule_raw[RL_TIMEOUT]  = timer_expired;
    rule_raw[RL_ERRPOS]   = cpl_err & ~complete_now;
    rule_raw[RL_B2B]      = done_q & access_now;
  end

  assign rule_fire = chk_en ? rule_raw : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_sticky <= '0;
      viol_pulse  <= 1'b0;
      viol_id     <= '0;
    end else begin
      viol_sticky <= viol_sticky | rule_fire;
      viol_pulse  <= |rule_fire;
      viol_id     <= lowest_rule(rule_fire);
    end
  end

endmodule

// File: rtl/apb_rule_monitor_sva.sv
module apb_rule_monitor_sva
  import apb_mon_pkg::*;
#(
  parameter  int SEL_W    = 4,
  parameter  int MAX_WAIT = 8,
  localparam int CNT_W    = $clog2(MAX_WAIT + 2)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [SEL_W-1:0]     req_sel,
  input logic                 req_enable,
  input logic                 cpl_ready,
  input logic                 cpl_err,
  input logic                 chk_en,
  input logic [CNT_W-1:0]     wait_cnt,
  input logic [RULE_CNT-1:0]  rule_fire,
  input logic [RULE_CNT-1:0]  viol_sticky,
  input logic                 viol_pulse,
  input logic [RULE_ID_W-1:0] viol_id
);

  p_sticky_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((viol_sticky & $past(viol_sticky)) == $past(viol_sticky)));

  p_fire_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rule_fire != '0) |=> ((viol_sticky & $past(rule_fire)) == $past(rule_fire)));

  p_pulse_on_fire_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rule_fire != '0) |=> viol_pulse);

  p_pulse_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rule_fire == '0) |=> !viol_pulse);

  p_id_lowest_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rule_fire != '0) |=>
      ((((int'($past(rule_fire)) >> viol_id) & 1) == 1) &&
       ((int'($past(rule_fire)) & ((1 << viol_id) - 1)) == 0)));

  p_multisel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && !$onehot0(req_sel)) |-> rule_fire[RL_MULTISEL]);

  p_errpos_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && cpl_err && !((req_sel != '0) && req_enable && cpl_ready))
      |=> viol_sticky[RL_ERRPOS]);

  p_enable_nosel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && req_enable && (req_sel == '0)) |=> viol_sticky[RL_ENABLE]);

  p_wait_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cnt <= CNT_W'(MAX_WAIT + 1));

endmodule

bind apb_rule_monitor apb_rule_monitor_sva #(
  .SEL_W    (SEL_W),
  .MAX_WAIT (MAX_WAIT)
) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_sel     (req_sel),
  .req_enable  (req_enable),
  .cpl_ready   (cpl_ready),
  .cpl_err     (cpl_err),
  .chk_en      (chk_en),
  .wait_cnt    (wait_cnt),
  .rule_fire   (rule_fire),
  .viol_sticky (viol_sticky),
  .viol_pulse  (viol_pulse),
  .viol_id     (viol_id)
);

// File: tb/apb_rule_monitor_tb_top.sv
`timescale 1ns/1ps
module apb_rule_monitor_tb_top;

  localparam int SEL_W    = 4;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 16;
  localparam int STRB_W   = DATA_W / 8;
  localparam int MAX_WAIT = 3;
  localparam int NRULE    = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [SEL_W-1:0]  req_sel = '0;
  logic              req_enable = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_write = 1'b0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic [STRB_W-1:0] req_strb = '0;
  logic              cpl_ready = 1'b0;
  logic              cpl_err = 1'b0;
  logic [5:0]        viol_sticky;
  logic              viol_pulse;
  logic [2:0]        viol_id;

  always #2.5 clk = ~clk;

  apb_rule_monitor #(
    .SEL_W(SEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_WAIT(MAX_WAIT)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_sel(req_sel), .req_enable(req_enable),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .req_strb(req_strb), .cpl_ready(cpl_ready), .cpl_err(cpl_err),
    .viol_sticky(viol_sticky), .viol_pulse(viol_pulse), .viol_id(viol_id)
  );

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  int pulse_seen;
  int first_id;
  int pulse_cnt [NRULE];

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic int low_bit(input int m);
    for (int i = 0; i < 32; i++) if (m[i]) return i;
    return -1;
  endfunction

  function automatic int popcnt(input int v);
    int c = 0;
    for (int i = 0; i < 32; i++) if (v[i]) c++;
    return c;
  endfunction

  task automatic clear_trk();
    pulse_seen = 0;
    first_id = -1;
    for (int i = 0; i < NRULE; i++) pulse_cnt[i] = 0;
  endtask

  // One bus cycle: inputs set away from the edge, outputs sampled 1 ns after it.
  task automatic cyc(input int s, input bit e, input bit r, input bit er);
    req_sel    = SEL_W'(s);
    req_enable = e;
    cpl_ready  = r;
    cpl_err    = er;
    @(posedge clk);
    #1;
    if (viol_pulse) begin
      pulse_seen |= (1 << viol_id);
      if (viol_id < NRULE) pulse_cnt[viol_id]++;
      if (first_id < 0) first_id = int'(viol_id);
    end
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0);
  endtask

  task automatic xfer(input int s, input int waits, input bit er);
    cyc(s, 0, 0, 0);
    for (int i = 0; i < waits; i++) cyc(s, 1, 0, 0);
    cyc(s, 1, 1, er);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_sel = '0; req_enable = 1'b0; cpl_ready = 1'b0; cpl_err = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b1;
    clear_trk();
  endtask

  // Reset, then one clean transfer and an idle cycle so checking is live.
  task automatic arm();
    do_reset();
    req_addr = 8'h10; req_write = 1'b1; req_wdata = 16'h1234; req_strb = 2'b11;
    xfer(1, 0, 0);
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    clear_trk();
    // R1: reset state
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk("R1", "sticky in reset", int'(viol_sticky), 0);
    chk("R1", "pulse in reset", int'(viol_pulse), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", "sticky after release", int'(viol_sticky), 0);
    chk("R1", "id after release", int'(viol_id), 0);

    // Legal traffic sweep: every select, both directions, waits 0..N,
    // with and without idle between transfers, error only at completion.
    do_reset();
    for (int s = 0; s < SEL_W; s++)
      for (int wr = 0; wr < 2; wr++)
        for (int w = 0; w <= MAX_WAIT; w++) begin
          req_addr  = ADDR_W'(s * 16 + w);
          req_write = wr[0];
          req_wdata = DATA_W'(s * 257 + w * 3 + wr);
          req_strb  = STRB_W'(w + 1);
          xfer(1 << s, w, wr[0]);
          if (w % 2 == 1) idle();
        end
    idle();
    chk("R2", "legal sweep sticky", int'(viol_sticky), 0);
    chk("R7", "legal sweep pulses", pulse_seen, 0);

    // R5: timeout sweep over wait counts
    for (int w = 0; w <= MAX_WAIT + 3; w++) begin
      arm();
      xfer(2, w, 0);
      idle();
      chk("R5", $sformatf("timeout sticky w=%0d", w), int'(viol_sticky), (w > MAX_WAIT) ? 8 : 0);
      chk("R5", $sformatf("timeout pulses w=%0d", w), pulse_cnt[3], (w > MAX_WAIT) ? 1 : 0);
    end

    // R2: each field changed, on the first access cycle or after a wait
    for (int f = 0; f < 4; f++)
      for (int pos = 0; pos < 2; pos++) begin
        arm();
        cyc(4, 0, 0, 0);
        if (pos == 1) cyc(4, 1, 0, 0);
        case (f)
          0: req_addr  = req_addr ^ 8'h01;
          1: req_write = ~req_write;
          2: req_wdata = req_wdata ^ 16'h8000;
          default: req_strb = req_strb ^ 2'b01;
        endcase
        cyc(4, 1, 1, 0);
        idle();
        chk("R2", $sformatf("hold f=%0d pos=%0d sticky", f, pos), int'(viol_sticky), 1);
        chk("R2", $sformatf("hold f=%0d pos=%0d id", f, pos), first_id, 0);
      end
    // R2: change after completion is legal
    arm();
    xfer(1, 1, 0);
    req_addr = 8'hEE; req_wdata = 16'h0F0F;
    idle();
    xfer(1, 0, 0);
    idle();
    chk("R2", "post-completion change", int'(viol_sticky), 0);

    // R3: enable without select; enable in first selected cycle
    arm();
    cyc(0, 1, 0, 0);
    idle();
    chk("R3", "enable no select", int'(viol_sticky), 2);
    arm();
    cyc(1, 1, 1, 0);
    idle();
    chk("R3", "enable in first cycle", int'(viol_sticky), 2);

    // R4: every select pattern
    for (int v = 0; v < (1 << SEL_W); v++) begin
      arm();
      cyc(v, 0, 0, 0);
      cyc(v, 1, 1, 0);
      idle();
      chk("R4", $sformatf("select pattern %0d", v), int'(viol_sticky),
          ((popcnt(v) > 1) ? 4 : 0) | ((v == 0) ? 2 : 0));
    end

    // R6 and R9: error strobe under every select/enable/ready mix
    for (int c = 0; c < 8; c++) begin
      int exp_m;
      arm();
      cyc(c[0] ? 1 : 0, c[1], c[2], 1);
      idle();
      exp_m = ((c[0] && c[1] && c[2]) ? 0 : 16) | (c[1] ? 2 : 0);
      chk("R6", $sformatf("error mix %0d sticky", c), int'(viol_sticky), exp_m);
      chk("R9", $sformatf("error mix %0d first id", c), first_id, low_bit(exp_m));
    end

    // R7 and R8: enable held across back-to-back boundary, then sticky holds
    arm();
    cyc(1, 0, 0, 0);
    cyc(1, 1, 1, 0);
    cyc(1, 1, 1, 0);
    chk("R9", "pulse right after b2b", int'(viol_pulse), 1);
    chk("R9", "id right after b2b", int'(viol_id), 5);
    idle();
    chk("R9", "pulse drops", int'(viol_pulse), 0);
    chk("R7", "b2b sticky", int'(viol_sticky), 32);
    for (int k = 0; k < 3; k++) begin
      xfer(1, k, 0);
      idle();
    end
    chk("R8", "sticky held", int'(viol_sticky), 32);
    chk("R8", "b2b pulsed once", pulse_cnt[5], 1);

    // R9: timeout and hold break in the same cycle
    arm();
    cyc(2, 0, 0, 0);
    for (int i = 0; i < MAX_WAIT; i++) cyc(2, 1, 0, 0);
    chk("R5", "no fire at N waits", int'(viol_sticky), 0);
    req_addr = req_addr ^ 8'h01;
    cyc(2, 1, 0, 0);
    chk("R9", "same-cycle pulse", int'(viol_pulse), 1);
    chk("R9", "same-cycle id", int'(viol_id), 0);
    chk("R9", "same-cycle sticky", int'(viol_sticky), 9);
    cyc(2, 1, 1, 0);
    idle();

    // R10: reset mid-transfer, silent until a new setup
    arm();
    cyc(1, 0, 0, 0);
    cyc(1, 1, 0, 0);
    rst_n = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    clear_trk();
    for (int i = 0; i < MAX_WAIT + 3; i++) cyc(1, 1, 0, 1);
    cyc(0, 1, 0, 0);
    cyc(3, 1, 0, 0);
    idle();
    chk("R10", "silent after reset sticky", int'(viol_sticky), 0);
    chk("R10", "silent after reset pulses", pulse_seen, 0);
    req_addr = 8'h55;
    cyc(1, 0, 0, 0);
    cyc(1, 1, 1, 0);
    cyc(1, 1, 1, 0);
    idle();
    chk("R10", "live after setup", int'(viol_sticky), 32);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule